// File: doc/BRIEF.md
# Segmented Address Pointer Unit

This block keeps the single address pointer that every serial-bus transaction of a register and nonvolatile-memory slave shares. The protocol engine asks it to preset the pointer from a command byte, or to advance it after each data byte written or read. The block answers with whether the requested preset is legal, so that the engine can refuse the byte. It also reports the current address, the memory segment that address falls in, whether the location may be written, and the value the pointer takes on the next advance.

The 8-bit address space holds three segments. Each one has its own rule at its upper end. The volatile register segment (00h–2Fh) stops at 2Fh, and 2Fh is a read-only location. The user nonvolatile segment (40h–7Fh) runs on into the configuration nonvolatile segment (80h–9Fh). The configuration nonvolatile segment stops at 9Fh. Where the pointer stops, any further bytes land on the same location, so the storage keeps only the last one. Addresses 30h–3Fh and A0h–FFh belong to no segment.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset, ptr_addr is 00h, ptr_valid is 1 and ptr_seg is 1.
- R2: preset_ok is 1 exactly when preset_addr lies in 00h–2Fh, 40h–7Fh or 80h–9Fh, in the same cycle.
- R3: A preset with preset_en high and a legal preset_addr puts that address on ptr_addr one clock later.
- R4: A preset with an illegal preset_addr leaves ptr_addr unchanged.
- R5: A step (wr_step or rd_step) without a preset raises ptr_addr by one inside a segment.
- R6: A step at 2Fh or at 9Fh leaves ptr_addr unchanged, so later bytes reuse that location.
- R7: A step at 7Fh moves ptr_addr to 80h.
- R8: wr_inhibit is 1 exactly when ptr_addr is 2Fh.
- R9: ptr_next always equals the ptr_addr that a step from the present state would produce.
- R10: rd_step follows the same rules as wr_step. Both high in one cycle count as a single step.
- R11: When preset_en is high, wr_step and rd_step are ignored in that cycle, whether the preset is legal or not.
- R12: ptr_seg encodes the segment of ptr_addr as 1 = 00h–2Fh, 2 = 40h–7Fh, 3 = 80h–9Fh. ptr_valid equals (ptr_seg != 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_en | input | 1 | Load request from a command byte |
| preset_addr | input | 8 | Address offered for the load |
| wr_step | input | 1 | Advance after a written data byte |
| rd_step | input | 1 | Advance after a read data byte |
| preset_ok | output | 1 | preset_addr falls inside a segment |
| ptr_addr | output | 8 | Current pointer |
| ptr_seg | output | 2 | Segment code of the current pointer |
| ptr_valid | output | 1 | Current pointer lies inside a segment |
| wr_inhibit | output | 1 | Current location is read-only |
| ptr_next | output | 8 | Pointer value after the next step |

## Verification
The pointer is the only state in the block, and each output is decoded from it or from preset_addr. A wrong stored address therefore shows on ptr_addr, ptr_seg, ptr_next and wr_inhibit in the cycle right after the faulty edge. The reference model is compared on every clock, so a fault is reported within one cycle. The boundary rules can only be seen while sitting at the end of a segment, so the stimulus drives long runs of steps at 2Fh, 7Fh and 9Fh. It also drives illegal presets and preset-with-step collisions.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,
      SEG_CREG = 2'd1,
      SEG_UNV  = 2'd2,
      SEG_CNV  = 2'd3
   } aptr_seg_e;

   localparam int unsigned SEG_COUNT = 3;
endpackage

// File: rtl/aptr_range_chk.sv
module aptr_range_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] LO = '0,
   parameter logic [ADDR_W-1:0] HI = '1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic lo_ok;
   logic hi_ok;

   if (LO == '0) begin : g_lo_open
      assign lo_ok = 1'b1;
   end else begin : g_lo_cmp
      assign lo_ok = (addr >= LO);
   end

   if (HI == '1) begin : g_hi_open
      assign hi_ok = 1'b1;
   end else begin : g_hi_cmp
      assign hi_ok = (addr <= HI);
   end

   assign hit = lo_ok & hi_ok;
endmodule

// File: rtl/aptr_seg_decode.sv
module aptr_seg_decode
   import aptr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_LO = 'h00,
   parameter logic [ADDR_W-1:0] REG_HI = 'h2F,
   parameter logic [ADDR_W-1:0] USR_LO = 'h40,
   parameter logic [ADDR_W-1:0] USR_HI = 'h7F,
   parameter logic [ADDR_W-1:0] NVC_LO = 'h80,
   parameter logic [ADDR_W-1:0] NVC_HI = 'h9F
) (
   input  logic [ADDR_W-1:0] addr,
   output aptr_seg_e         seg
);
   localparam logic [ADDR_W-1:0] LO_TAB [SEG_COUNT] = '{REG_LO, USR_LO, NVC_LO};
   localparam logic [ADDR_W-1:0] HI_TAB [SEG_COUNT] = '{REG_HI, USR_HI, NVC_HI};

   logic [SEG_COUNT-1:0] hits;

   for (genvar i = 0; i < int'(SEG_COUNT); i++) begin : g_seg
      aptr_range_chk #(
         .ADDR_W (ADDR_W),
         .LO     (LO_TAB[i]),
         .HI     (HI_TAB[i])
      ) i_chk (
         .addr (addr),
         .hit  (hits[i])
      );
   end

   always_comb begin
      seg = SEG_NONE;
      if (hits[0])      seg = SEG_CREG;
      else if (hits[1]) seg = SEG_UNV;
      else if (hits[2]) seg = SEG_CNV;
   end
endmodule

// File: rtl/aptr_step_logic.sv
module aptr_step_logic
   import aptr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_HI = 'h2F,
   parameter logic [ADDR_W-1:0] USR_HI = 'h7F,
   parameter logic [ADDR_W-1:0] NVC_LO = 'h80,
   parameter logic [ADDR_W-1:0] NVC_HI = 'h9F,
   parameter bit USER_ROLLS = 1'b1
) (
   input  logic [ADDR_W-1:0] ptr,
   input  aptr_seg_e         seg,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] usr_end;

   assign inc = ptr + ADDR_W'(1);

   if (USER_ROLLS) begin : g_roll
      assign usr_end = NVC_LO;
   end else begin : g_hold
      assign usr_end = ptr;
   end

   always_comb begin
      nxt = ptr;
      unique case (seg)
         SEG_CREG: nxt = (ptr == REG_HI) ? ptr : inc;
         SEG_UNV:  nxt = (ptr == USR_HI) ? usr_end : inc;
         SEG_CNV:  nxt = (ptr == NVC_HI) ? ptr : inc;
         default:  nxt = ptr;
      endcase
   end
endmodule

// File: rtl/aptr_ro_mask.sv
module aptr_ro_mask #(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] RO_ADDR = 'h2F,
   parameter bit RO_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] ptr,
   output logic              inhibit
);
   if (RO_EN) begin : g_mask
      assign inhibit = (ptr == RO_ADDR);
   end else begin : g_open
      logic unused_ok;
      assign unused_ok = ^ptr;
      assign inhibit   = 1'b0 & unused_ok;
   end
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
   import aptr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_LO = 'h00,
   parameter logic [ADDR_W-1:0] REG_HI = 'h2F,
   parameter logic [ADDR_W-1:0] USR_LO = 'h40,
   parameter logic [ADDR_W-1:0] USR_HI = 'h7F,
   parameter logic [ADDR_W-1:0] NVC_LO = 'h80,
   parameter logic [ADDR_W-1:0] NVC_HI = 'h9F,
   parameter logic [ADDR_W-1:0] RO_ADDR = 'h2F,
   parameter bit USER_ROLLS = 1'b1,
   parameter bit RO_EN = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preset_en,
   input  logic [ADDR_W-1:0] preset_addr,
   input  logic              wr_step,
   input  logic              rd_step,
   output logic              preset_ok,
   output logic [ADDR_W-1:0] ptr_addr,
   output logic [1:0]        ptr_seg,
   output logic              ptr_valid,
   output logic              wr_inhibit,
   output logic [ADDR_W-1:0] ptr_next
);
   localparam logic [ADDR_W-1:0] R2F = RO_ADDR;

   if (ADDR_W < 2) begin : g_bad_w
      $error("addr_ptr_unit: ADDR_W too small");
   end
   if (!(REG_LO <= REG_HI && REG_HI < USR_LO && USR_LO <= USR_HI &&
         USR_HI < NVC_LO && NVC_LO <= NVC_HI)) begin : g_bad_map
      $error("addr_ptr_unit: segments must be ordered and disjoint");
   end
   if (USER_ROLLS && (NVC_LO != USR_HI + ADDR_W'(1))) begin : g_bad_roll
      $error("addr_ptr_unit: roll-over needs adjacent segments");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] step_val;
   aptr_seg_e         cur_seg;
   aptr_seg_e         req_seg;
   logic              step;

   aptr_seg_decode #(
      .ADDR_W (ADDR_W), .REG_LO (REG_LO), .REG_HI (REG_HI),
      .USR_LO (USR_LO), .USR_HI (USR_HI), .NVC_LO (NVC_LO), .NVC_HI (NVC_HI)
   ) i_req_dec (
      .addr (preset_addr),
      .seg  (req_seg)
   );

   aptr_seg_decode #(
      .ADDR_W (ADDR_W), .REG_LO (REG_LO), .REG_HI (REG_HI),
      .USR_LO (USR_LO), .USR_HI (USR_HI), .NVC_LO (NVC_LO), .NVC_HI (NVC_HI)
   ) i_cur_dec (
      .addr (ptr_q),
      .seg  (cur_seg)
   );

   aptr_step_logic #(
      .ADDR_W (ADDR_W), .REG_HI (REG_HI), .USR_HI (USR_HI),
      .NVC_LO (NVC_LO), .NVC_HI (NVC_HI), .USER_ROLLS (USER_ROLLS)
   ) i_step (
      .ptr (ptr_q),
      .seg (cur_seg),
      .nxt (step_val)
   );

   aptr_ro_mask #(
      .ADDR_W (ADDR_W), .RO_ADDR (RO_ADDR), .RO_EN (RO_EN)
   ) i_ro (
      .ptr     (ptr_q),
      .inhibit (wr_inhibit)
   );

   assign step      = wr_step | rd_step;
   assign preset_ok = (req_seg != SEG_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= RESET_ADDR;
      end else if (preset_en) begin
         if (preset_ok) ptr_q <= preset_addr;
      end else if (step) begin
         ptr_q <= step_val;
      end
   end

   assign ptr_addr  = ptr_q;
   assign ptr_seg   = cur_seg;
   assign ptr_valid = (cur_seg != SEG_NONE);
   assign ptr_next  = step_val;

   // R3: legal preset loads
   a_r3_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
      preset_en && preset_ok |=> ptr_addr == $past(preset_addr));

   // R4 and R11: rejected preset holds, steps ignored
   a_r4_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      preset_en && !preset_ok |=> $stable(ptr_addr));

   // R6: saturating ends
   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_en && step && (ptr_addr == REG_HI || ptr_addr == NVC_HI) |=> $stable(ptr_addr));

   // R7: user segment rolls into configuration nonvolatile segment
   a_r7_roll: assert property (@(posedge clk) disable iff (!rst_n)
      USER_ROLLS && !preset_en && step && ptr_addr == USR_HI |=> ptr_addr == NVC_LO);

   // R9: the advertised next value is what a step produces
   a_r9_next_match: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_en && step |=> ptr_addr == $past(ptr_next));

   // R1/R12: pointer never leaves the map
   a_r12_stay_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_valid);

   // R8: read-only location flag
   a_r8_ro_flag: assert property (@(posedge clk) disable iff (!rst_n)
      RO_EN && wr_inhibit |-> ptr_addr == R2F && ptr_seg == 2'd1);
endmodule

// File: tb/test_addr_ptr_unit.sv
`timescale 1ns/1ps
module test_addr_ptr_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       preset_en = 1'b0;
   logic [7:0] preset_addr = 8'h00;
   logic       wr_step = 1'b0;
   logic       rd_step = 1'b0;
   logic       preset_ok;
   logic [7:0] ptr_addr;
   logic [1:0] ptr_seg;
   logic       ptr_valid;
   logic       wr_inhibit;
   logic [7:0] ptr_next;

   int total = 0;
   int bad = 0;
   int ref_ptr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   addr_ptr_unit i_addr_ptr_unit (
      .clk, .rst_n, .preset_en, .preset_addr, .wr_step, .rd_step,
      .preset_ok, .ptr_addr, .ptr_seg, .ptr_valid, .wr_inhibit, .ptr_next
   );

   function automatic bit m_legal(int a);
      return (a <= 'h2F) || (a >= 'h40 && a <= 'h9F);
   endfunction

   function automatic int m_seg(int a);
      if (a <= 'h2F) return 1;
      if (a >= 'h40 && a <= 'h7F) return 2;
      if (a >= 'h80 && a <= 'h9F) return 3;
      return 0;
   endfunction

   function automatic int m_step(int a);
      if (!m_legal(a) || a == 'h2F || a == 'h9F) return a;
      return a + 1;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(string req);
      chk(req, "ptr_addr", int'(ptr_addr), ref_ptr);
      chk("R12", "ptr_seg", int'(ptr_seg), m_seg(ref_ptr));
      chk("R12", "ptr_valid", int'(ptr_valid), int'(m_seg(ref_ptr) != 0));
      chk("R8", "wr_inhibit", int'(wr_inhibit), int'(ref_ptr == 'h2F));
      chk("R9", "ptr_next", int'(ptr_next), m_step(ref_ptr));
   endtask

   // drive one cycle after a negedge, check at the next negedge
   task automatic cyc(bit pe, int pa, bit ws, bit rs, string req);
      preset_en   = pe;
      preset_addr = pa[7:0];
      wr_step     = ws;
      rd_step     = rs;
      #1;
      chk("R2", "preset_ok", int'(preset_ok), int'(m_legal(pa)));
      @(posedge clk);
      if (pe) begin
         if (m_legal(pa)) ref_ptr = pa;
      end else if (ws || rs) begin
         ref_ptr = m_step(ref_ptr);
      end
      @(negedge clk);
      chk_state(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset ptr", int'(ptr_addr), 0);
      chk("R1", "reset valid", int'(ptr_valid), 1);
      chk("R1", "reset seg", int'(ptr_seg), 1);
      cyc(1, 'h10, 0, 0, "R3");
      for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, "R5");
      cyc(1, 'h2D, 0, 0, "R3");
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, "R6");
      cyc(1, 'h35, 0, 0, "R4");
      cyc(1, 'h3F, 1, 0, "R4");
      cyc(1, 'hA0, 0, 1, "R4");
      cyc(1, 'hFF, 0, 0, "R4");
      cyc(1, 'h7E, 0, 0, "R3");
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, "R7");
      cyc(1, 'h7F, 0, 0, "R3");
      cyc(0, 0, 1, 1, "R10");
      cyc(1, 'h9D, 0, 0, "R3");
      for (int i = 0; i < 5; i++) cyc(0, 0, i[0], !i[0], "R6");
      cyc(1, 'h40, 1, 1, "R11");
      cyc(1, 'h00, 0, 1, "R11");
      cyc(0, 0, 0, 1, "R10");
      cyc(1, 'h2F, 0, 0, "R8");
      cyc(0, 0, 0, 0, "R8");
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 9);
         int a = (r < 3) ? $urandom_range(0, 255) :
                 (r == 3) ? 'h2E : (r == 4) ? 'h7D : (r == 5) ? 'h9E : -1;
         if (a >= 0) cyc(1, a, $urandom_range(0, 1) == 1, 0, "R3");
         else cyc(0, 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R5");
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200us;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule